// File: doc/BRIEF.md
# Memory Instruction Replay Manager

This block parks memory instructions that could not complete on their first attempt and hands them back for another issue once whatever held them up has gone away. It keeps every parked instruction in one shared pool of slots. Each occupied slot is in one of three states. A slot is waiting on address translation when a hardware table walk is still running. A slot is blocked when the data cache refused the access. A slot is eligible for retry when a cache-unblocked notification has released it.

The issue logic reads two independent pop ports. The translation pop offers the oldest waiting instruction whose translation has finished. The retry pop offers the oldest retry-eligible instruction. Each port shows "none" when it has nothing to offer. A retried instruction that the cache refuses again is sent back through the block request, so it returns to the blocked state. A squash removes one thread's wrong-path entries. When the pool cannot take a new request, the block raises a stall so that the requester holds the request instead of losing it.

Top module: `mrm_replay_mgr`

## Requirements
- R1: After reset the pool is empty: both pop ports show no instruction and the stall output is low while no request is presented.
- R2: A defer request stores its (sequence number, thread) as waiting on translation. That entry is not offered on the translation pop until a translation-done indication with the same sequence number and thread has been presented on an earlier cycle.
- R3: The translation pop offers, in the same cycle, the translation-complete entry with the smallest sequence number, or no instruction if there is none. If the pop request is high while an entry is offered, that entry leaves the pool at the next clock edge.
- R4: A block request stores its entry as blocked. A blocked entry is never offered on the retry pop, and it stays blocked until a cache-unblocked pulse arrives.
- R5: A cache-unblocked pulse turns every entry that is blocked at that clock edge into a retry entry. A block request accepted in the same cycle as the pulse stays blocked.
- R6: The retry pop offers, in the same cycle, the retry entry with the smallest sequence number, or no instruction if there is none. If the pop request is high while an entry is offered, that entry leaves the pool at the next clock edge.
- R7: A retry entry that is popped and then presented again as a block request becomes blocked again. It needs a new cache-unblocked pulse before it can be offered again.
- R8: A squash with (thread T, sequence S) removes from all three states every entry of thread T whose sequence number is greater than S. Entries of other threads, and entries of T with a sequence number at or below S, stay in the pool.
- R9: The pool holds at most CAP entries. Stall is high exactly when the number of requests in the cycle (defer plus block, 0 to 2) exceeds the number of free slots at the start of the cycle. In a stalled cycle neither request is stored.
- R10: Sequence numbers are compared as unsigned values without wrap-around. Every state change (insert, pop removal, unblock, translation done, squash) takes effect at the clock edge, and it is visible on the outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| defer_valid_i | input | 1 | Request to park an instruction that is waiting on translation |
| defer_seq_i | input | SEQ_W | Sequence number of the deferred instruction |
| defer_tid_i | input | TID_W | Thread of the deferred instruction |
| block_valid_i | input | 1 | Request to park an instruction that the cache refused |
| block_seq_i | input | SEQ_W | Sequence number of the blocked instruction |
| block_tid_i | input | TID_W | Thread of the blocked instruction |
| xlate_done_i | input | 1 | Translation finished for the named entry |
| xlate_seq_i | input | SEQ_W | Sequence number whose translation finished |
| xlate_tid_i | input | TID_W | Thread whose translation finished |
| cache_unblock_i | input | 1 | Pulse: the cache accepts accesses again |
| squash_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Entries younger than this sequence number are removed |
| squash_tid_i | input | TID_W | Thread being squashed |
| defer_pop_i | input | 1 | Take the offered translation-complete entry |
| defer_pop_valid_o | output | 1 | A translation-complete entry is offered |
| defer_pop_seq_o | output | SEQ_W | Sequence number of the offered entry |
| defer_pop_tid_o | output | TID_W | Thread of the offered entry |
| retry_pop_i | input | 1 | Take the offered retry entry |
| retry_pop_valid_o | output | 1 | A retry entry is offered |
| retry_pop_seq_o | output | SEQ_W | Sequence number of the offered retry entry |
| retry_pop_tid_o | output | TID_W | Thread of the offered retry entry |
| stall_o | output | 1 | The requests in this cycle do not fit and were not stored |

## Verification
A slot stuck in the wrong state shows up on the very next cycle as a wrong valid flag on one of the pop ports. Examples are a blocked entry that was never released or a translation flag that was never set. A slot that was freed too early or never freed shows up as a mismatch in sequence number or thread on the next pop, or as a stall raised one request too early or too late near capacity. A wrong age comparison puts a younger instruction on a pop port in the same cycle that the older one becomes eligible, so the bench compares both pop ports and the stall against a reference model on every clock.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

   // Lifecycle of one pool slot.
   typedef enum logic [1:0] {
      ST_FREE  = 2'd0,
      ST_XLATE = 2'd1,
      ST_BLOCK = 2'd2,
      ST_RETRY = 2'd3
   } slot_st_e;

endpackage

// File: rtl/mrm_free_find.sv
// Finds the two lowest-numbered free slots of the pool.
module mrm_free_find #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     busy_i,
   output logic             found0_o,
   output logic [IDX_W-1:0] idx0_o,
   output logic             found1_o,
   output logic [IDX_W-1:0] idx1_o
);

   if (N < 2) begin : g_bad_n
      $error("mrm_free_find: N must be at least 2");
   end

   always_comb begin
      found0_o = 1'b0;
      idx0_o   = '0;
      found1_o = 1'b0;
      idx1_o   = '0;
      for (int k = 0; k < N; k++) begin
         if (!busy_i[k]) begin
            if (!found0_o) begin
               found0_o = 1'b1;
               idx0_o   = IDX_W'(k);
            end else if (!found1_o) begin
               found1_o = 1'b1;
               idx1_o   = IDX_W'(k);
            end
         end
      end
   end

endmodule

// File: rtl/mrm_oldest_pick.sv
// Picks the candidate with the smallest sequence number; ties go to the
// lower slot index. USE_TREE selects a balanced comparison tree instead of
// a linear scan.
module mrm_oldest_pick #(
   parameter int N        = 8,
   parameter int SEQ_W    = 16,
   parameter int IDX_W    = 3,
   parameter bit USE_TREE = 1'b1
) (
   input  logic [N-1:0]            cand_i,
   input  logic [N-1:0][SEQ_W-1:0] seq_i,
   output logic                    found_o,
   output logic [IDX_W-1:0]        idx_o
);

   if (N < 2) begin : g_bad_n
      $error("mrm_oldest_pick: N must be at least 2");
   end
   if (IDX_W < $clog2(N)) begin : g_bad_idx
      $error("mrm_oldest_pick: IDX_W too narrow for N");
   end

   if (USE_TREE) begin : g_tree
      localparam int LVL   = $clog2(N);
      localparam int LEAFS = 1 << LVL;
      localparam int NODES = 2 * LEAFS - 1;

      logic             nv [NODES];
      logic [SEQ_W-1:0] ns [NODES];
      logic [IDX_W-1:0] ni [NODES];

      for (genvar k = 0; k < LEAFS; k++) begin : g_leaf
         if (k < N) begin : g_real
            assign nv[LEAFS-1+k] = cand_i[k];
            assign ns[LEAFS-1+k] = seq_i[k];
            assign ni[LEAFS-1+k] = IDX_W'(k);
         end else begin : g_pad
            assign nv[LEAFS-1+k] = 1'b0;
            assign ns[LEAFS-1+k] = '0;
            assign ni[LEAFS-1+k] = '0;
         end
      end

      for (genvar n = 0; n < LEAFS - 1; n++) begin : g_node
         logic take_left;
         assign take_left = nv[2*n+1] &&
                            (!nv[2*n+2] || (ns[2*n+1] <= ns[2*n+2]));
         assign nv[n] = nv[2*n+1] | nv[2*n+2];
         assign ns[n] = take_left ? ns[2*n+1] : ns[2*n+2];
         assign ni[n] = take_left ? ni[2*n+1] : ni[2*n+2];
      end

      assign found_o = nv[0];
      assign idx_o   = ni[0];
   end else begin : g_scan
      always_comb begin
         logic [SEQ_W-1:0] best;
         found_o = 1'b0;
         idx_o   = '0;
         best    = '0;
         for (int k = 0; k < N; k++) begin
            if (cand_i[k] && (!found_o || (seq_i[k] < best))) begin
               found_o = 1'b1;
               idx_o   = IDX_W'(k);
               best    = seq_i[k];
            end
         end
      end
   end

endmodule

// File: rtl/mrm_replay_mgr.sv
module mrm_replay_mgr #(
   parameter int CAP       = 8,
   parameter int SEQ_W     = 16,
   parameter int NUM_THR   = 4,
   parameter bit PICK_TREE = 1'b1,
   localparam int TID_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
   localparam int IDX_W    = $clog2(CAP),
   localparam int OCC_W    = $clog2(CAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             defer_valid_i,
   input  logic [SEQ_W-1:0] defer_seq_i,
   input  logic [TID_W-1:0] defer_tid_i,
   input  logic             block_valid_i,
   input  logic [SEQ_W-1:0] block_seq_i,
   input  logic [TID_W-1:0] block_tid_i,
   input  logic             xlate_done_i,
   input  logic [SEQ_W-1:0] xlate_seq_i,
   input  logic [TID_W-1:0] xlate_tid_i,
   input  logic             cache_unblock_i,
   input  logic             squash_i,
   input  logic [SEQ_W-1:0] squash_seq_i,
   input  logic [TID_W-1:0] squash_tid_i,
   input  logic             defer_pop_i,
   output logic             defer_pop_valid_o,
   output logic [SEQ_W-1:0] defer_pop_seq_o,
   output logic [TID_W-1:0] defer_pop_tid_o,
   input  logic             retry_pop_i,
   output logic             retry_pop_valid_o,
   output logic [SEQ_W-1:0] retry_pop_seq_o,
   output logic [TID_W-1:0] retry_pop_tid_o,
   output logic             stall_o
);
   import mrm_pkg::*;

   if (CAP < 2) begin : g_bad_cap
      $error("mrm_replay_mgr: CAP must be at least 2");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("mrm_replay_mgr: SEQ_W must be positive");
   end
   if (NUM_THR < 1) begin : g_bad_thr
      $error("mrm_replay_mgr: NUM_THR must be positive");
   end

   // Slot storage
   slot_st_e         st_q   [CAP];
   logic [SEQ_W-1:0] seq_q  [CAP];
   logic [TID_W-1:0] tid_q  [CAP];
   logic             done_q [CAP];

   // Per-slot views
   logic [CAP-1:0]            busy;
   logic [CAP-1:0]            blk_mask;
   logic [CAP-1:0]            rty_mask;
   logic [CAP-1:0]            rdy_mask;
   logic [CAP-1:0][SEQ_W-1:0] seq_pk;

   for (genvar i = 0; i < CAP; i++) begin : g_view
      assign busy[i]     = (st_q[i] != ST_FREE);
      assign blk_mask[i] = (st_q[i] == ST_BLOCK);
      assign rty_mask[i] = (st_q[i] == ST_RETRY);
      assign rdy_mask[i] = (st_q[i] == ST_XLATE) && done_q[i];
      assign seq_pk[i]   = seq_q[i];
   end

   // Occupancy and admission
   logic [OCC_W-1:0] occ_cnt;
   logic [OCC_W-1:0] free_cnt;
   logic [1:0]       need;
   logic             accept;

   always_comb begin
      occ_cnt = '0;
      for (int k = 0; k < CAP; k++) begin
         occ_cnt = occ_cnt + OCC_W'(busy[k]);
      end
   end

   assign free_cnt = OCC_W'(CAP) - occ_cnt;
   assign need     = {1'b0, defer_valid_i} + {1'b0, block_valid_i};
   assign stall_o  = (OCC_W'(need) > free_cnt);
   assign accept   = !stall_o;

   // Slot allocation
   logic             f0_found;
   logic             f1_found;
   logic [IDX_W-1:0] f0_idx;
   logic [IDX_W-1:0] f1_idx;
   logic [IDX_W-1:0] blk_slot;
   logic             ins_xl;
   logic             ins_blk;

   mrm_free_find #(
      .N     (CAP),
      .IDX_W (IDX_W)
   ) u_free (
      .busy_i   (busy),
      .found0_o (f0_found),
      .idx0_o   (f0_idx),
      .found1_o (f1_found),
      .idx1_o   (f1_idx)
   );

   assign ins_xl   = accept && defer_valid_i;
   assign ins_blk  = accept && block_valid_i;
   assign blk_slot = defer_valid_i ? f1_idx : f0_idx;

   // Oldest pickers
   logic             xl_found;
   logic [IDX_W-1:0] xl_idx;
   logic             rt_found;
   logic [IDX_W-1:0] rt_idx;

   mrm_oldest_pick #(
      .N        (CAP),
      .SEQ_W    (SEQ_W),
      .IDX_W    (IDX_W),
      .USE_TREE (PICK_TREE)
   ) u_pick_xlate (
      .cand_i  (rdy_mask),
      .seq_i   (seq_pk),
      .found_o (xl_found),
      .idx_o   (xl_idx)
   );

   mrm_oldest_pick #(
      .N        (CAP),
      .SEQ_W    (SEQ_W),
      .IDX_W    (IDX_W),
      .USE_TREE (PICK_TREE)
   ) u_pick_retry (
      .cand_i  (rty_mask),
      .seq_i   (seq_pk),
      .found_o (rt_found),
      .idx_o   (rt_idx)
   );

   assign defer_pop_valid_o = xl_found;
   assign defer_pop_seq_o   = xl_found ? seq_q[xl_idx] : '0;
   assign defer_pop_tid_o   = xl_found ? tid_q[xl_idx] : '0;
   assign retry_pop_valid_o = rt_found;
   assign retry_pop_seq_o   = rt_found ? seq_q[rt_idx] : '0;
   assign retry_pop_tid_o   = rt_found ? tid_q[rt_idx] : '0;

   // Slot update
   for (genvar i = 0; i < CAP; i++) begin : g_slot
      logic kill;
      logic xl_hit;

      assign kill =
         (defer_pop_i && xl_found && (xl_idx == IDX_W'(i))) ||
         (retry_pop_i && rt_found && (rt_idx == IDX_W'(i))) ||
         (squash_i && busy[i] && (tid_q[i] == squash_tid_i) &&
          (seq_q[i] > squash_seq_i));

      assign xl_hit = xlate_done_i && (st_q[i] == ST_XLATE) &&
                      (seq_q[i] == xlate_seq_i) && (tid_q[i] == xlate_tid_i);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[i]   <= ST_FREE;
            seq_q[i]  <= '0;
            tid_q[i]  <= '0;
            done_q[i] <= 1'b0;
         end else if (busy[i]) begin
            if (kill) begin
               st_q[i]   <= ST_FREE;
               done_q[i] <= 1'b0;
            end else begin
               if (xl_hit) begin
                  done_q[i] <= 1'b1;
               end
               if (cache_unblock_i && (st_q[i] == ST_BLOCK)) begin
                  st_q[i] <= ST_RETRY;
               end
            end
         end else if (ins_xl && (f0_idx == IDX_W'(i))) begin
            st_q[i]   <= ST_XLATE;
            seq_q[i]  <= defer_seq_i;
            tid_q[i]  <= defer_tid_i;
            done_q[i] <= 1'b0;
         end else if (ins_blk && (blk_slot == IDX_W'(i))) begin
            st_q[i]   <= ST_BLOCK;
            seq_q[i]  <= block_seq_i;
            tid_q[i]  <= block_tid_i;
            done_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mrm_replay_mgr_chk.sv
module mrm_replay_mgr_chk #(
   parameter int CAP   = 8,
   parameter int OCC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             defer_valid_i,
   input logic             block_valid_i,
   input logic             cache_unblock_i,
   input logic             squash_i,
   input logic             stall_o,
   input logic             defer_pop_valid_o,
   input logic             retry_pop_valid_o,
   input logic [OCC_W-1:0] occ_cnt,
   input logic [CAP-1:0]   blk_mask,
   input logic [CAP-1:0]   rty_mask,
   input logic [CAP-1:0]   rdy_mask
);

   // R9: occupancy never exceeds capacity
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      occ_cnt <= OCC_W'(CAP));

   // R9: a full pool stalls any request
   p_full_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((occ_cnt == OCC_W'(CAP)) && (defer_valid_i || block_valid_i)) |-> stall_o);

   // R9: stall only when something is requested
   p_stall_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> (defer_valid_i || block_valid_i));

   // R5: an unblock with no new block request leaves nothing blocked
   p_unblock_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_unblock_i && !block_valid_i) |=> (blk_mask == '0));

   // R4: blocked entries persist without unblock or squash
   p_blocked_persist_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((blk_mask != '0) && !cache_unblock_i && !squash_i) |=> (blk_mask != '0));

   // R6: nothing offered for retry when no retry entry exists
   p_retry_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rty_mask == '0) |-> !retry_pop_valid_o);

   // R2: translation pop offers only translation-complete entries
   p_xlate_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      defer_pop_valid_o |-> (rdy_mask != '0));

endmodule

bind mrm_replay_mgr mrm_replay_mgr_chk #(
   .CAP   (CAP),
   .OCC_W (OCC_W)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .defer_valid_i     (defer_valid_i),
   .block_valid_i     (block_valid_i),
   .cache_unblock_i   (cache_unblock_i),
   .squash_i          (squash_i),
   .stall_o           (stall_o),
   .defer_pop_valid_o (defer_pop_valid_o),
   .retry_pop_valid_o (retry_pop_valid_o),
   .occ_cnt           (occ_cnt),
   .blk_mask          (blk_mask),
   .rty_mask          (rty_mask),
   .rdy_mask          (rdy_mask)
);

// File: tb/mrm_replay_mgr_tb.sv
module mrm_replay_mgr_tb_top;

   localparam int CAP   = 8;
   localparam int SEQ_W = 16;
   localparam int TID_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             defer_valid_i = 1'b0;
   logic [SEQ_W-1:0] defer_seq_i = '0;
   logic [TID_W-1:0] defer_tid_i = '0;
   logic             block_valid_i = 1'b0;
   logic [SEQ_W-1:0] block_seq_i = '0;
   logic [TID_W-1:0] block_tid_i = '0;
   logic             xlate_done_i = 1'b0;
   logic [SEQ_W-1:0] xlate_seq_i = '0;
   logic [TID_W-1:0] xlate_tid_i = '0;
   logic             cache_unblock_i = 1'b0;
   logic             squash_i = 1'b0;
   logic [SEQ_W-1:0] squash_seq_i = '0;
   logic [TID_W-1:0] squash_tid_i = '0;
   logic             defer_pop_i = 1'b0;
   logic             retry_pop_i = 1'b0;
   logic             defer_pop_valid_o;
   logic [SEQ_W-1:0] defer_pop_seq_o;
   logic [TID_W-1:0] defer_pop_tid_o;
   logic             retry_pop_valid_o;
   logic [SEQ_W-1:0] retry_pop_seq_o;
   logic [TID_W-1:0] retry_pop_tid_o;
   logic             stall_o;

   always #5 clk = ~clk;

   mrm_replay_mgr #(
      .CAP     (CAP),
      .SEQ_W   (SEQ_W),
      .NUM_THR (4)
   ) dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .defer_valid_i     (defer_valid_i),
      .defer_seq_i       (defer_seq_i),
      .defer_tid_i       (defer_tid_i),
      .block_valid_i     (block_valid_i),
      .block_seq_i       (block_seq_i),
      .block_tid_i       (block_tid_i),
      .xlate_done_i      (xlate_done_i),
      .xlate_seq_i       (xlate_seq_i),
      .xlate_tid_i       (xlate_tid_i),
      .cache_unblock_i   (cache_unblock_i),
      .squash_i          (squash_i),
      .squash_seq_i      (squash_seq_i),
      .squash_tid_i      (squash_tid_i),
      .defer_pop_i       (defer_pop_i),
      .defer_pop_valid_o (defer_pop_valid_o),
      .defer_pop_seq_o   (defer_pop_seq_o),
      .defer_pop_tid_o   (defer_pop_tid_o),
      .retry_pop_i       (retry_pop_i),
      .retry_pop_valid_o (retry_pop_valid_o),
      .retry_pop_seq_o   (retry_pop_seq_o),
      .retry_pop_tid_o   (retry_pop_tid_o),
      .stall_o           (stall_o)
   );

   // Reference model: 1 = waiting translation, 2 = blocked, 3 = retry
   typedef struct {
      int seq;
      int tid;
      int st;
      bit done;
   } ent_t;

   ent_t mq[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 0;

   task automatic check_int(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int oldest(int st, bit need_done);
      int best = -1;
      for (int k = 0; k < mq.size(); k++) begin
         if (mq[k].st == st && (!need_done || mq[k].done)) begin
            if (best < 0 || mq[k].seq < mq[best].seq) best = k;
         end
      end
      return best;
   endfunction

   // One cycle: compare outputs to the model, then advance the model.
   task automatic cyc(string req);
      int   dix;
      int   rix;
      int   need;
      bit   exp_stall;
      ent_t nq[$];
      #1;
      dix = oldest(1, 1'b1);
      rix = oldest(3, 1'b0);
      need = int'(defer_valid_i) + int'(block_valid_i);
      exp_stall = need > (CAP - mq.size());
      check_int({req, "/R9"}, "stall", int'(stall_o), int'(exp_stall));
      check_int({req, "/R3"}, "xlate valid", int'(defer_pop_valid_o), int'(dix >= 0));
      if (dix >= 0) begin
         check_int({req, "/R3"}, "xlate seq", int'(defer_pop_seq_o), mq[dix].seq);
         check_int({req, "/R3"}, "xlate tid", int'(defer_pop_tid_o), mq[dix].tid);
      end
      check_int({req, "/R6"}, "retry valid", int'(retry_pop_valid_o), int'(rix >= 0));
      if (rix >= 0) begin
         check_int({req, "/R6"}, "retry seq", int'(retry_pop_seq_o), mq[rix].seq);
         check_int({req, "/R6"}, "retry tid", int'(retry_pop_tid_o), mq[rix].tid);
      end
      for (int k = 0; k < mq.size(); k++) begin
         ent_t e = mq[k];
         bit gone = (defer_pop_i && k == dix) || (retry_pop_i && k == rix) ||
                    (squash_i && e.tid == int'(squash_tid_i) &&
                     e.seq > int'(squash_seq_i));
         if (!gone) begin
            if (xlate_done_i && e.st == 1 && e.seq == int'(xlate_seq_i) &&
                e.tid == int'(xlate_tid_i)) e.done = 1'b1;
            if (cache_unblock_i && e.st == 2) e.st = 3;
            nq.push_back(e);
         end
      end
      if (!exp_stall) begin
         if (defer_valid_i) nq.push_back('{int'(defer_seq_i), int'(defer_tid_i), 1, 1'b0});
         if (block_valid_i) nq.push_back('{int'(block_seq_i), int'(block_tid_i), 2, 1'b0});
      end
      mq = nq;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      defer_valid_i = 0; block_valid_i = 0; xlate_done_i = 0;
      cache_unblock_i = 0; squash_i = 0; defer_pop_i = 0; retry_pop_i = 0;
   endtask

   task automatic do_defer(int s, int t);
      defer_valid_i = 1; defer_seq_i = SEQ_W'(s); defer_tid_i = TID_W'(t);
   endtask

   task automatic do_block(int s, int t);
      block_valid_i = 1; block_seq_i = SEQ_W'(s); block_tid_i = TID_W'(t);
   endtask

   task automatic do_xlate(int s, int t);
      xlate_done_i = 1; xlate_seq_i = SEQ_W'(s); xlate_tid_i = TID_W'(t);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state visible while reset is still held
      check_int("R1", "xlate valid in reset", int'(defer_pop_valid_o), 0);
      check_int("R1", "retry valid in reset", int'(retry_pop_valid_o), 0);
      check_int("R1", "stall in reset", int'(stall_o), 0);
      rst_n = 1;
      cyc("R1");

      // R2: deferred entries hidden until translation done
      do_defer(10, 0); cyc("R2"); idle_inputs();
      do_defer(5, 1);  cyc("R2"); idle_inputs();
      do_defer(7, 0);  defer_pop_i = 1; cyc("R2"); idle_inputs();
      do_xlate(10, 1); cyc("R2"); idle_inputs();  // wrong thread: no effect
      cyc("R2");
      do_xlate(10, 0); cyc("R2"); idle_inputs();
      cyc("R10");
      // R3: oldest ready first
      do_xlate(5, 1); cyc("R3"); idle_inputs();
      defer_pop_i = 1; do_xlate(7, 0); cyc("R3"); idle_inputs();
      defer_pop_i = 1; cyc("R3"); idle_inputs();
      defer_pop_i = 1; cyc("R3"); idle_inputs();
      cyc("R3");

      // R4: blocked entries are not retry candidates
      do_block(20, 2); cyc("R4"); idle_inputs();
      do_block(15, 0); retry_pop_i = 1; cyc("R4"); idle_inputs();
      do_block(30, 1); cyc("R4"); idle_inputs();
      cyc("R4");
      // R5: unblock with a simultaneous block request
      cache_unblock_i = 1; do_block(12, 3); cyc("R5"); idle_inputs();
      cyc("R5");
      // R6: oldest retry popped
      retry_pop_i = 1; cyc("R6"); idle_inputs();
      // R7: re-blocked entry waits for another unblock
      do_block(15, 0); cyc("R7"); idle_inputs();
      retry_pop_i = 1; cyc("R7"); idle_inputs();
      retry_pop_i = 1; cyc("R7"); idle_inputs();
      cyc("R7");
      cache_unblock_i = 1; cyc("R7"); idle_inputs();
      cyc("R7");

      // R8: squash across all states
      do_defer(40, 0); cyc("R8"); idle_inputs();
      do_defer(41, 1); do_block(42, 0); cyc("R8"); idle_inputs();
      do_xlate(40, 0); do_block(11, 0); cyc("R8"); idle_inputs();
      squash_i = 1; squash_seq_i = 12; squash_tid_i = 0; cyc("R8"); idle_inputs();
      cyc("R8");
      do_xlate(41, 1); cyc("R8"); idle_inputs();
      cyc("R8");

      // R9: fill to capacity, then over-subscribe
      for (int k = 0; k < 8; k++) begin
         do_defer(100 + k, k % 4); cyc("R9"); idle_inputs();
      end
      do_defer(200, 0); do_block(201, 1); cyc("R9"); idle_inputs();
      do_block(202, 2); cyc("R9"); idle_inputs();
      squash_i = 1; squash_seq_i = 0; squash_tid_i = 0; cyc("R9"); idle_inputs();
      cyc("R9");
      do_defer(300, 1); do_block(301, 2); cyc("R9"); idle_inputs();
      do_defer(302, 1); do_block(303, 2); cyc("R9"); idle_inputs();
      for (int k = 0; k < 4; k++) begin
         squash_i = 1; squash_seq_i = 0; squash_tid_i = TID_W'(k);
         cyc("R8"); idle_inputs();
      end
      cyc("R1");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule